// File: doc/BRIEF.md
# DAC Group Auto-Range Controller

This block holds the output-range code for each of four converter groups, A to D. Every group has a comparator flag that goes high when its negative supply rail sits below a threshold. The block resamples these flags through a synchronizer and uses them to pick each group's range: a negative rail selects the −10 V to 0 V span, and a grounded rail selects the 0 V to 5 V span. The detector results are also kept in their own read-only status register.

Detection runs once after reset. It runs again whenever software writes to the device-configuration register or to either of the two power-down registers. Between detection events, software can give any group any of the four spans through two range registers, each holding two groups. Reads of those registers return the range currently in effect. The analog comparators, converter cores and clamps lie outside the block. It acts only on digital flags.

Top module: `dac_autorange_ctrl`

## Requirements
- R1: While rst_n is low, every group's range code is 00 (0 to 5 V) and the status register reads 0.
- R2: After rst_n rises, the synchronized flags are loaded on the third rising edge. Each group gets code 11 (−10 to 0 V) if its flag is 1, or 00 if its flag is 0. Before that edge the codes stay 00.
- R3: A write to address 0x1E sets group A from data bits [1:0] and group B from bits [3:2]. A write to 0x1F sets group C from [1:0] and group D from [3:2]. The codes are 00 = 0 to 5 V, 01 = 0 to 10 V, 10 = −5 to 0 V, 11 = −10 to 0 V. Data bits [7:4] are ignored.
- R4: A read of 0x1E or 0x1F returns the codes in effect, packed as in R3, with bits [7:4] reading 0.
- R5: A write to 0x02, 0xB2 or 0xB3 leaves the ranges unchanged on the edge that takes the write. On the next edge it reloads all four ranges and the status bits from the synchronized flags.
- R6: On the edge where a detection reload happens, a write to 0x1E or 0x1F is discarded and the reload wins.
- R7: Status register 0x72 holds the last detection result in bits [3:0], with bit 0 for A through bit 3 for D, and 1 meaning a negative rail. Writes to 0x72 have no effect.
- R8: Flag inputs pass through a two-stage synchronizer. A reload uses the flag value that was present two edges before the reload edge, not the value at the trigger write.
- R9: Writes to any other address change nothing, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| neg_flag_in | input | 4 | Asynchronous negative-rail flags, bit 0 = A through bit 3 = D |
| grp_range | output | 8 | Range codes in effect, group g in bits [2g+1:2g] |
| neg_status | output | 4 | Last detection result, same bit order as the flags |

## Verification
The bench builds the block with its default parameters: four groups, two groups per 8-bit range register, and a two-stage synchronizer. These values fix the three-edge boot latency and the one-edge trigger latency, so the bench can check both exactly. They also make the synchronizer delay visible, by changing a flag in the same cycle as a trigger write. Because both range registers are populated, back-to-back trigger and range writes can show that the reload takes priority.

// File: rtl/dar_pkg.sv
package dar_pkg;
  localparam int unsigned CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    RNG_P5  = 2'b00,
    RNG_P10 = 2'b01,
    RNG_N5  = 2'b10,
    RNG_N10 = 2'b11
  } rng_code_e;

  localparam int unsigned REG_CFG    = 'h02;
  localparam int unsigned REG_PD0    = 'hB2;
  localparam int unsigned REG_PD1    = 'hB3;
  localparam int unsigned REG_RANGE0 = 'h1E;
  localparam int unsigned REG_STATUS = 'h72;

  // detector mapping: negative rail -> widest negative span
  function automatic logic [CODE_W-1:0] det_code(input logic neg);
    return neg ? RNG_N10 : RNG_P5;
  endfunction
endpackage

// File: rtl/dar_sync.sv
module dar_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) pipe[s] <= '0;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < int'(STAGES); s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/dar_group.sv
module dar_group
  import dar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              det_fire,
  input  logic              neg_flag,
  input  logic              sw_we,
  input  logic [CODE_W-1:0] sw_code,
  output logic [CODE_W-1:0] range_q,
  output logic              stat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      range_q <= RNG_P5;
      stat_q  <= 1'b0;
    end else if (det_fire) begin
      range_q <= det_code(neg_flag);
      stat_q  <= neg_flag;
    end else if (sw_we) begin
      range_q <= sw_code;
    end
  end
endmodule

// File: rtl/dac_autorange_ctrl.sv
module dac_autorange_ctrl
  import dar_pkg::*;
#(
  parameter int unsigned NUM_GRP     = 4,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  input  logic [NUM_GRP-1:0]         neg_flag_in,
  output logic [NUM_GRP*CODE_W-1:0]  grp_range,
  output logic [NUM_GRP-1:0]         neg_status
);
  localparam int unsigned GRP_PER_REG = 2;
  localparam int unsigned NUM_REG     = (NUM_GRP + GRP_PER_REG - 1) / GRP_PER_REG;
  localparam int unsigned FIELD_W     = GRP_PER_REG * CODE_W;
  localparam int unsigned CNT_MAX     = SYNC_STAGES + 1;
  localparam int unsigned CNT_W       = $clog2(CNT_MAX + 1);

  function automatic logic is_trigger(input logic [ADDR_W-1:0] a);
    return (a == ADDR_W'(REG_CFG)) || (a == ADDR_W'(REG_PD0)) || (a == ADDR_W'(REG_PD1));
  endfunction

  // synchronized comparator flags
  logic [NUM_GRP-1:0] flag_s;
  dar_sync #(.W(NUM_GRP), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(neg_flag_in), .q(flag_s)
  );

  // boot detection once the synchronizer has filled
  logic [CNT_W-1:0] boot_cnt;
  logic             boot_fire;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           boot_cnt <= '0;
    else if (boot_cnt != CNT_W'(CNT_MAX)) boot_cnt <= boot_cnt + 1'b1;
  end
  assign boot_fire = (boot_cnt == CNT_W'(SYNC_STAGES));

  // write-triggered detection, one edge after the write
  logic trig_hit, trig_q, det_fire;
  assign trig_hit = wr_en && is_trigger(wr_addr);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_hit;
  end
  assign det_fire = boot_fire | trig_q;

  // per-register write decode
  logic [NUM_REG-1:0] reg_we;
  logic               range_we_any;
  for (genvar r = 0; r < int'(NUM_REG); r++) begin : g_dec
    assign reg_we[r] = wr_en && (wr_addr == ADDR_W'(REG_RANGE0 + r));
  end
  assign range_we_any = |reg_we;

  // group state
  for (genvar g = 0; g < int'(NUM_GRP); g++) begin : g_grp
    localparam int unsigned RIDX = g / GRP_PER_REG;
    localparam int unsigned SLOT = g % GRP_PER_REG;
    dar_group u_grp (
      .clk      (clk),
      .rst_n    (rst_n),
      .det_fire (det_fire),
      .neg_flag (flag_s[g]),
      .sw_we    (reg_we[RIDX]),
      .sw_code  (wr_data[SLOT*CODE_W +: CODE_W]),
      .range_q  (grp_range[g*CODE_W +: CODE_W]),
      .stat_q   (neg_status[g])
    );
  end

  // read mux
  logic [NUM_REG*FIELD_W-1:0] range_pad;
  always_comb begin
    range_pad = '0;
    range_pad[NUM_GRP*CODE_W-1:0] = grp_range;
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < int'(NUM_REG); r++) begin
      if (rd_addr == ADDR_W'(REG_RANGE0 + r))
        rd_data[FIELD_W-1:0] = range_pad[r*FIELD_W +: FIELD_W];
    end
    if (rd_addr == ADDR_W'(REG_STATUS))
      rd_data[NUM_GRP-1:0] = neg_status;
  end
endmodule

// File: rtl/dar_checker.sv
module dar_checker #(
  parameter int unsigned NUM_GRP = 4,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [ADDR_W-1:0]       wr_addr,
  input logic [DATA_W-1:0]       wr_data,
  input logic [ADDR_W-1:0]       rd_addr,
  input logic [DATA_W-1:0]       rd_data,
  input logic [NUM_GRP-1:0]      flag_s,
  input logic                    det_fire,
  input logic                    range_we_any,
  input logic [NUM_GRP*2-1:0]    grp_range,
  input logic [NUM_GRP-1:0]      neg_status
);
  logic trig_wr;
  assign trig_wr = wr_en && (wr_addr == ADDR_W'(8'h02) || wr_addr == ADDR_W'(8'hB2) ||
                             wr_addr == ADDR_W'(8'hB3));

  // R3: software write lands on the following edge when no reload competes
  a_r3_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(8'h1E) && !det_fire) |=> grp_range[3:0] == $past(wr_data[3:0]));

  // R4: readback of the first range register matches the range outputs
  a_r4_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_W'(8'h1E)) |-> (rd_data == DATA_W'(grp_range[3:0])));

  // R5: status holds the synchronized flags two edges after a trigger write
  a_r5_trig_status: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr |=> ##1 (neg_status == $past(flag_s)));

  // R6: a reload maps each flag to its span, regardless of a competing write
  for (genvar g = 0; g < int'(NUM_GRP); g++) begin : g_r6
    a_r6_det_over_sw: assert property (@(posedge clk) disable iff (!rst_n)
      det_fire |=> (grp_range[2*g +: 2] == ($past(flag_s[g]) ? 2'b11 : 2'b00)));
  end

  // R7: status changes only on a reload
  a_r7_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !det_fire |=> $stable(neg_status));

  // R9: ranges hold when neither reload nor range write occurs
  a_r9_range_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_fire && !range_we_any) |=> $stable(grp_range));
endmodule

bind dac_autorange_ctrl dar_checker #(
  .NUM_GRP(NUM_GRP), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .flag_s(flag_s), .det_fire(det_fire),
  .range_we_any(range_we_any), .grp_range(grp_range), .neg_status(neg_status)
);

// File: tb/sim_dac_autorange_ctrl.sv
module sim_dac_autorange_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [3:0] flags = '0;
  logic [7:0] grp_range;
  logic [3:0] neg_status;

  always #5 clk = ~clk;

  dac_autorange_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .neg_flag_in(flags),
    .grp_range(grp_range), .neg_status(neg_status)
  );

  typedef struct {
    int         kind;   // 0 = read port, 1 = range outputs, 2 = status outputs
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  // detector result as seen on the range outputs: 3 for negative, 0 otherwise
  function automatic logic [7:0] spans(input logic [3:0] f);
    logic [7:0] v = '0;
    for (int g = 0; g < 4; g++) if (f[g]) v[2*g +: 2] = 2'd3;
    return v;
  endfunction

  // monitor: compares the oldest expectation against the design mid-cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = rd_data;
        1:       act = grp_range;
        default: act = {4'b0, neg_status};
      endcase
      total++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  // driver: push an expectation and wait for the monitor to consume it
  task automatic expect_item(input int kind, input logic [7:0] addr,
                             input logic [7:0] exp, input string tag);
    item_t it;
    rd_addr = addr;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    flags = 4'b1010;
    repeat (3) step();
    expect_item(1, 8'h00, 8'h00, "R1 ranges in reset");
    expect_item(0, 8'h72, 8'h00, "R1 status in reset");
    @(posedge clk); #1; rst_n = 1'b1;
    step(); step();
    expect_item(1, 8'h00, 8'h00, "R2 not loaded before third edge");
    step();
    expect_item(1, 8'h00, spans(4'b1010), "R2 boot ranges");
    expect_item(0, 8'h72, 8'h0A, "R7 status after boot");
    expect_item(0, 8'h1E, 8'h0C, "R4 read A/B after boot");

    wr(8'h1E, 8'hF9);
    expect_item(1, 8'h00, 8'hC9, "R3 write A/B");
    expect_item(0, 8'h1E, 8'h09, "R4 read A/B masks upper bits");
    wr(8'h1F, 8'h06);
    expect_item(1, 8'h00, 8'h69, "R3 write C/D");
    expect_item(0, 8'h1F, 8'h06, "R4 read C/D");

    wr(8'h72, 8'hFF);
    expect_item(0, 8'h72, 8'h0A, "R7 status write ignored");
    wr(8'h55, 8'hFF);
    expect_item(1, 8'h00, 8'h69, "R9 stray write no effect");
    expect_item(0, 8'h55, 8'h00, "R9 stray read zero");

    flags = 4'b0101;
    repeat (4) step();
    wr(8'h02, 8'h00);
    expect_item(1, 8'h00, 8'h69, "R5 no change on write edge");
    step();
    expect_item(1, 8'h00, spans(4'b0101), "R5 reload after config write");
    expect_item(2, 8'h00, 8'h05, "R5 status after config write");

    flags = 4'b1111;
    repeat (4) step();
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = 8'hB2; wr_data = 8'h00;
    @(posedge clk); #1;
    wr_addr = 8'h1E; wr_data = 8'h00;
    @(posedge clk); #1;
    wr_en = 1'b0;
    expect_item(1, 8'h00, 8'hFF, "R6 reload beats range write");
    expect_item(0, 8'h1E, 8'h0F, "R6 readback after reload");

    flags = 4'b0000;
    repeat (4) step();
    wr(8'hB3, 8'h00);
    step();
    expect_item(1, 8'h00, 8'h00, "R5 reload after power-down write");

    @(posedge clk); #1;
    flags = 4'b1111; wr_en = 1'b1; wr_addr = 8'hB2;
    @(posedge clk); #1;
    wr_en = 1'b0;
    step();
    expect_item(1, 8'h00, 8'h00, "R8 reload uses synchronized old flags");
    wr(8'h02, 8'h00);
    step();
    expect_item(1, 8'h00, 8'hFF, "R8 later reload sees new flags");
    expect_item(0, 8'h72, 8'h0F, "R7 status all negative");

    step();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule